// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block carries out PHY management transactions from one 32-bit command register. The host writes a fully formatted frame word into the register. If the management port is enabled and no transaction is running, the write starts a transaction. The controller sends a preamble on the serial data line, shifts the 32-bit word out MSB first, and generates the management clock by dividing the system clock.

For a read frame, the controller releases the data line at the turnaround. It samples the bits the PHY returns and, when the frame ends, places them in the low half of the same register. The host polls an idle flag to learn when the result is ready, then reads the register back.

The host-side word uses a fixed field layout: bits 31:30 start code, 29:28 operation, 27:23 PHY address, 22:18 PHY register, 17:16 turnaround, 15:0 data.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, `idle` is 1, `mdc` is 0, `mdio_oe` is 0 and `cmd_rdata` is 0.
- R2: A command write while `mgmt_en` is 0 is ignored. `idle` stays 1, `mdc` stays low and `cmd_rdata` keeps its earlier value.
- R3: An accepted write makes `idle` 0 from the next cycle. `idle` returns to 1 exactly 64*DIV cycles after the accepting edge.
- R4: Each frame begins with 32 MDC periods in which MDIO is driven high.
- R5: After the preamble, the 32 command bits are driven MSB first (bit 31 first), one bit per MDC period.
- R6: For a read frame (bits 29:28 equal to 2'b10), `mdio_oe` is 0 from frame bit 17 (the first turnaround bit) to the end of the frame. For a write frame, MDIO is driven for all 64 periods.
- R7: In a read frame, MDIO is sampled on each rising MDC edge of frame bits 15 down to 0, MSB first. On completion these bits replace `cmd_rdata[15:0]`, and bits 31:16 are kept.
- R8: Completing a write frame leaves `cmd_rdata` equal to the written command.
- R9: A command write while a transaction is in progress is ignored. The register and the frame on the wire keep the first command.
- R10: MDC has a period of DIV system clocks with DIV/2 clocks high. It stays low while idle.
- R11: An accepted command appears on `cmd_rdata` from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mgmt_en | input | 1 | Management port enable; writes are accepted only when this is 1 |
| cmd_wr | input | 1 | One-cycle write strobe for the command register |
| cmd_wdata | input | 32 | Formatted frame word to write |
| cmd_rdata | output | 32 | Command register contents; holds read data in bits 15:0 after a read |
| idle | output | 1 | 1 when no transaction is in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data value to drive |
| mdio_oe | output | 1 | Output enable for the serial data pad |
| mdio_i | input | 1 | Serial data value seen at the pad |

## Verification
The assertions assume the following about the inputs:
- `cmd_wr` is a single-cycle strobe.
- The PHY changes `mdio_i` only away from the system-clock edge at which MDC rises.
- `mgmt_en` may change at any time; once a transaction has started, it runs to completion regardless.

The bench PHY model meets these assumptions. It updates its data bit right after each MDC rise, so the controller samples a value that has been stable for a full MDC period. Command strobes are driven on the falling system-clock edge and last one cycle. Commands that overlap a transaction are issued only to exercise the busy-drop rule.

// File: rtl/mdio_mgmt_pkg.sv
// Shared field positions and codes of the management command word.
// Assumes the host formats the whole frame word, including the start code.
package mdio_mgmt_pkg;
    localparam int WORD_W   = 32;           // bits in one management frame
    localparam int PRE_LEN  = 32;           // preamble periods before the frame
    localparam int DATA_W   = 16;           // data field width
    localparam int OP_HI    = 29;           // operation field, upper bit
    localparam int OP_LO    = 28;           // operation field, lower bit
    localparam int TA_HI    = 17;           // first turnaround bit
    localparam logic [1:0] OP_READ = 2'b10; // read operation code
endpackage

// File: rtl/mdio_clk_div.sv
// Management clock generator: divides clk by DIV while run is high.
// Gives a strobe on the cycle MDC rises and on the last cycle of each period.
// Assumes DIV is even and at least 2; the counter restarts whenever run drops.
module mdio_clk_div #(
    parameter int DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic end_stb
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    // period counter, held at zero while stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (cnt == CW'(DIV - 1))
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign rise_stb = run && (cnt == CW'(HALF - 1));
    assign end_stb  = run && (cnt == CW'(DIV - 1));

    // clock output: high for the second half of each period
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            mdc <= 1'b0;
        else if (rise_stb)
            mdc <= 1'b1;
        else if (end_stb)
            mdc <= 1'b0;
    end

    assert_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |=> mdc);
    assert_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        end_stb |=> !mdc);
endmodule

// File: rtl/mdio_frame_seq.sv
// Frame sequencer: walks preamble then frame bits, one per MDC period.
// Drives or releases the data line and collects read data on rising MDC.
// Assumes start is raised only while busy is low.
module mdio_frame_seq
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              rise_stb,
    input  logic              end_stb,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rd_data
);
    localparam int TOTAL   = PRE_LEN + WORD_W;
    localparam int IW      = $clog2(TOTAL);
    localparam int FW      = $clog2(WORD_W);
    localparam int REL_IDX = PRE_LEN + (WORD_W - 1 - TA_HI);
    localparam int CAP_IDX = TOTAL - DATA_W;

    logic [IW-1:0]     bit_idx;
    logic [WORD_W-1:0] shadow;
    logic              is_rd;
    logic [FW-1:0]     fpos;

    assign done = busy && end_stb && (bit_idx == IW'(TOTAL - 1));

    // sequencing state: load on start, advance at each period end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            bit_idx <= '0;
            shadow  <= '0;
            is_rd   <= 1'b0;
        end else if (start) begin
            busy    <= 1'b1;
            bit_idx <= '0;
            shadow  <= cmd_word;
            is_rd   <= (cmd_word[OP_HI:OP_LO] == OP_READ);
        end else if (done) begin
            busy    <= 1'b0;
        end else if (busy && end_stb) begin
            bit_idx <= bit_idx + 1'b1;
        end
    end

    // read capture: shift in PHY data on rising MDC, MSB first
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (busy && rise_stb && (bit_idx >= IW'(CAP_IDX)))
            rd_data <= {rd_data[DATA_W-2:0], mdio_i};
    end

    // output data: ones in preamble, then command bits MSB first
    always_comb begin
        fpos = FW'(WORD_W - 1) - FW'(bit_idx - IW'(PRE_LEN));
        if (!busy || bit_idx < IW'(PRE_LEN))
            mdio_o = 1'b1;
        else
            mdio_o = shadow[fpos];
    end

    assign mdio_oe = busy && !(is_rd && bit_idx >= IW'(REL_IDX));

    assert_preamble_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bit_idx < IW'(PRE_LEN)) |-> (mdio_o && mdio_oe));
    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_rd && bit_idx >= IW'(CAP_IDX)) |-> !mdio_oe);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
// Top of the management controller: holds the command register, accepts
// writes only when enabled and idle, and merges read data on completion.
// Assumes cmd_wr is a one-cycle strobe from the host.
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mgmt_en,
    input  logic              cmd_wr,
    input  logic [WORD_W-1:0] cmd_wdata,
    output logic [WORD_W-1:0] cmd_rdata,
    output logic              idle,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic [WORD_W-1:0] cmd_reg;
    logic              busy, done, accept, rise_stb, end_stb;
    logic [DATA_W-1:0] rd_data;

    assign accept = cmd_wr && mgmt_en && !busy;

    mdio_clk_div #(.DIV(DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .run(busy),
        .mdc(mdc), .rise_stb(rise_stb), .end_stb(end_stb)
    );

    mdio_frame_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(accept), .cmd_word(cmd_wdata),
        .rise_stb(rise_stb), .end_stb(end_stb), .mdio_i(mdio_i),
        .busy(busy), .done(done), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .rd_data(rd_data)
    );

    // command register: host load, read-data merge at end of a read frame
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_reg <= '0;
        else if (accept)
            cmd_reg <= cmd_wdata;
        else if (done && cmd_reg[OP_HI:OP_LO] == OP_READ)
            cmd_reg[DATA_W-1:0] <= rd_data;
    end

    assign cmd_rdata = cmd_reg;
    assign idle      = !busy;

    assert_busy_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && cmd_wr) |=> $stable(cmd_reg));
    assert_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && cmd_wr && !mgmt_en) |=> (idle && $stable(cmd_reg)));
    assert_idle_mdc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !mdc);
    assert_upper_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(cmd_reg[WORD_W-1:DATA_W]));
endmodule

// File: tb/sim_mdio_mgmt_ctrl.sv
`timescale 1ns/100ps
module sim_mdio_mgmt_ctrl;
    localparam int DIV = 32;
    localparam int TOT = 64 * DIV;

    logic        clk = 1'b0, rst_n = 1'b0, mgmt_en = 1'b0, cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0, cmd_rdata;
    logic        idle, mdc, mdio_o, mdio_oe, mdio_i;

    int n_chk = 0, n_fail = 0;
    int rcount = 64;
    logic [15:0] phy_val = '0;
    logic obit [64];
    logic ooe  [64];

    mdio_mgmt_ctrl #(.DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .mgmt_en(mgmt_en), .cmd_wr(cmd_wr),
        .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata), .idle(idle),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #2.5 clk = ~clk;

    // PHY model: record the line on each rising MDC, supply read data bits
    always @(posedge mdc) begin
        if (rcount >= 0 && rcount < 64) begin
            obit[rcount] = mdio_o;
            ooe[rcount]  = mdio_oe;
        end
        rcount = rcount + 1;
    end
    always_comb begin
        if (rcount >= 48 && rcount < 64) mdio_i = phy_val[63 - rcount];
        else                             mdio_i = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] pa,
                                       input logic [4:0] ra, input logic [15:0] d);
        return {2'b01, op, pa, ra, 2'b10, d};
    endfunction

    // one transaction with timing, wire and register checks; optional late write
    task automatic run_txn(input logic [31:0] cmd, input bit intrude,
                           input logic [31:0] exp_final);
        int highs = 0, bad_pre = 0, bad_bits = 0, bad_oe = 0;
        bit rd = (cmd[29:28] == 2'b10);
        @(negedge clk);
        cmd_wdata = cmd; cmd_wr = 1'b1; rcount = 0;
        @(negedge clk);
        cmd_wr = 1'b0;
        chk(idle == 1'b0, "R3 busy after write", {31'b0, idle}, 32'd0);
        chk(cmd_rdata == cmd, "R11 readback", cmd_rdata, cmd);
        if (mdc) highs++;
        for (int k = 1; k < TOT; k++) begin
            if (intrude && k == 300) begin cmd_wdata = ~cmd; cmd_wr = 1'b1; end
            if (intrude && k == 301) cmd_wr = 1'b0;
            @(negedge clk);
            if (mdc) highs++;
        end
        chk(idle == 1'b0, "R3 still busy at last cycle", {31'b0, idle}, 32'd0);
        @(negedge clk);
        chk(idle == 1'b1, "R3 idle after 64*DIV", {31'b0, idle}, 32'd1);
        chk(highs == 64 * (DIV / 2), "R10 mdc high count", highs, 64 * (DIV / 2));
        for (int i = 0; i < 64; i++) begin
            if (i < 32) begin
                if (!(obit[i] && ooe[i])) bad_pre++;
            end else if (rd && i >= 46) begin
                if (ooe[i]) bad_oe++;
            end else begin
                if (!ooe[i]) bad_oe++;
                if (obit[i] !== cmd[63 - i]) bad_bits++;
            end
        end
        chk(bad_pre == 0, "R4 preamble", bad_pre, 0);
        chk(bad_bits == 0, "R5 frame bits", bad_bits, 0);
        chk(bad_oe == 0, "R6 drive enable", bad_oe, 0);
        chk(cmd_rdata == exp_final, rd ? "R7 read result" : "R8 write keeps word",
            cmd_rdata, exp_final);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R10 quiet when idle",
            {30'b0, mdc, mdio_oe}, 32'd0);
    endtask

    task automatic t_reset;
        chk(idle == 1'b1, "R1 idle", {31'b0, idle}, 32'd1);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins", {30'b0, mdc, mdio_oe}, 32'd0);
        chk(cmd_rdata == 32'd0, "R1 register", cmd_rdata, 32'd0);
    endtask

    task automatic t_disabled;
        int highs = 0, busy_seen = 0;
        mgmt_en = 1'b0;
        @(negedge clk);
        cmd_wdata = 32'h6F5A_1234; cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        for (int k = 0; k < 100; k++) begin
            if (mdc) highs++;
            if (!idle) busy_seen++;
            @(negedge clk);
        end
        chk(busy_seen == 0 && highs == 0, "R2 no transaction", busy_seen + highs, 0);
        chk(cmd_rdata == 32'd0, "R2 register untouched", cmd_rdata, 32'd0);
    endtask

    task automatic t_write;
        logic [31:0] c = mk(2'b01, 5'h05, 5'h03, 16'hBEEF);
        mgmt_en = 1'b1;
        run_txn(c, 1'b0, c);
    endtask

    task automatic t_read(input logic [4:0] pa, input logic [4:0] ra,
                          input logic [15:0] v);
        logic [31:0] c = mk(2'b10, pa, ra, 16'h0000);
        phy_val = v;
        run_txn(c, 1'b0, {c[31:16], v});
    endtask

    task automatic t_busy_write;
        logic [31:0] c = mk(2'b01, 5'h11, 5'h0A, 16'h3C3C);
        // R9: the second write lands mid-frame; the first word must survive
        run_txn(c, 1'b1, c);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_write();
        t_read(5'h1F, 5'h1F, 16'hA5C3);
        t_read(5'h01, 5'h00, 16'h8001);
        t_busy_write();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule